// File: doc/BRIEF.md
# Write-Protect Sequence Guard

This block sits beside an 8K-byte nonvolatile memory and watches every host write cycle: one strobe with a 13-bit address and an 8-bit data byte. It recognises short key runs written to two magic addresses. It keeps a global protection flag and an 8-bit per-block lock mask, where each bit covers one 1K-byte block. For each write cycle it decides, in that same cycle, whether the byte may reach the array. Cycles that belong to a key run are marked as consumed and never reach the array.

Protection has two levels. The global flag gates all data writes. A three-byte key run opens a window for the page of data that follows, and the window closes when the page ends. Above this, the lock mask refuses writes to a locked block whatever the global flag or the window say. Two five-byte runs, which extend the three-byte key, either clear the global flag or load the lock mask from the byte that follows. The stored state is modelled as plain registers that load defaults at reset.

Top module: `wp_guard_top`

## Requirements
- R1: After reset protectEn is 0 and lockMask is 8'h00, and a write to any address that is not part of a key run gives writeAllow=1.
- R2: The key run 8'hAA at 12'h555, then 8'h55 at 12'hAAA, then 8'hA0 at 12'h555 marks each of its three cycles with cmdConsumed=1 and writeAllow=0, and sets protectEn to 1 from the cycle after its last byte.
- R3: While protectEn=1 and no page window is open, a data write gives writeAllow=0 with cmdConsumed=0.
- R4: Once the last byte of the key run has been written, data writes to unlocked blocks give writeAllow=1 until a cycle with pageDone=1. From the next cycle on they give writeAllow=0.
- R5: Key addresses are compared on address bits 11:0 only, so bit 12 has no effect on recognition.
- R6: The key run followed by 8'hAA at 12'h555 and 8'h80 at 12'hAAA clears protectEn to 0. All five cycles are consumed.
- R7: The key run followed by 8'hAA at 12'h555 and 8'hC0 at 12'hAAA makes the next written byte, at any address, the new lockMask. All six cycles are consumed.
- R8: lockMask bit n covers the addresses whose bits 12:10 equal n, and 1 means locked. A write to a locked block gives writeAllow=0 even when protectEn=0 or a page window is open.
- R9: A write that does not match the expected next step of a run returns the recogniser to idle, gives cmdConsumed=0, and is judged as an ordinary data write.
- R10: With wrStrobe=0, writeAllow and cmdConsumed are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads default protection state |
| wrStrobe | input | 1 | One host write cycle |
| wrAddr | input | 13 | Write address |
| wrData | input | 8 | Write data byte |
| pageDone | input | 1 | End of the current page window |
| writeAllow | output | 1 | The byte of this cycle may be written to the array |
| cmdConsumed | output | 1 | This cycle belongs to a key run |
| protectEn | output | 1 | Global protection flag |
| lockMask | output | 8 | Per-block lock bits |

## Verification
The bench sweeps both edges of all eight blocks under each protection state: reset default, protected with the window closed, window open, a mixed lock mask with the window open, and protection cleared with the mask still set. The expected result is computed from the mask bit and the two flags. A design that lets the window override a lock, or that decodes the block from the wrong address bits, would pass writes at the wrong block boundary. The bench runs the key with address bit 12 set to catch a full 13-bit compare. It breaks a run halfway through, with the window open and with it closed, to catch a recogniser that eats or drops the breaking byte. It writes the mask byte at an address with no key meaning, to catch a mask load that checks the address.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_KEY1,
    SEQ_KEY2,
    SEQ_OPEN,
    SEQ_EXT4,
    SEQ_MASK
  } seqState_t;

  typedef struct packed {
    logic consumed;
    logic unlockHit;
    logic protOff;
    logic maskLoad;
  } ctlStrobe_t;

endpackage

// File: rtl/wp_seq_ctrl.sv
module wp_seq_ctrl
  import wp_pkg::*;
#(
  parameter int CMP_W    = 12,
  parameter int DATA_W   = 8,
  parameter logic [CMP_W-1:0]  KEY_ADDR_A = 12'h555,
  parameter logic [CMP_W-1:0]  KEY_ADDR_B = 12'hAAA,
  parameter logic [DATA_W-1:0] KEY_BYTE_1 = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_BYTE_2 = 8'h55,
  parameter logic [DATA_W-1:0] KEY_BYTE_3 = 8'hA0,
  parameter logic [DATA_W-1:0] CODE_OFF   = 8'h80,
  parameter logic [DATA_W-1:0] CODE_LOCK  = 8'hC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrStrobe,
  input  logic [CMP_W-1:0]  addrLow,
  input  logic [DATA_W-1:0] wrData,
  output ctlStrobe_t        ctl
);

  seqState_t seqState, seqNext;

  logic atA, atB;
  assign atA = (addrLow == KEY_ADDR_A);
  assign atB = (addrLow == KEY_ADDR_B);

  always_comb begin
    seqNext = seqState;
    ctl     = '0;
    if (wrStrobe) begin
      seqNext = SEQ_IDLE;
      unique case (seqState)
        SEQ_IDLE: if (atA && wrData == KEY_BYTE_1) begin
          seqNext = SEQ_KEY1; ctl.consumed = 1'b1;
        end
        SEQ_KEY1: if (atB && wrData == KEY_BYTE_2) begin
          seqNext = SEQ_KEY2; ctl.consumed = 1'b1;
        end
        SEQ_KEY2: if (atA && wrData == KEY_BYTE_3) begin
          seqNext = SEQ_OPEN; ctl.consumed = 1'b1; ctl.unlockHit = 1'b1;
        end
        SEQ_OPEN: if (atA && wrData == KEY_BYTE_1) begin
          seqNext = SEQ_EXT4; ctl.consumed = 1'b1;
        end
        SEQ_EXT4: begin
          if (atB && wrData == CODE_OFF) begin
            ctl.consumed = 1'b1; ctl.protOff = 1'b1;
          end else if (atB && wrData == CODE_LOCK) begin
            seqNext = SEQ_MASK; ctl.consumed = 1'b1;
          end
        end
        SEQ_MASK: begin
          ctl.consumed = 1'b1; ctl.maskLoad = 1'b1;
        end
        default: seqNext = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seqState <= SEQ_IDLE;
    else        seqState <= seqNext;
  end

  // R7: the mask-load step is only reached through a lock-code byte
  assert_mask_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seqState == SEQ_MASK) |-> $past(wrStrobe && atB && wrData == CODE_LOCK))
    else $error("mask step entered without lock code");

endmodule

// File: rtl/wp_prot_dp.sv
module wp_prot_dp
  import wp_pkg::*;
#(
  parameter int NBLK = 8,
  parameter logic             PROT_RESET = 1'b0,
  parameter logic [NBLK-1:0]  LOCK_RESET = '0,
  localparam int BLK_W = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrStrobe,
  input  logic [BLK_W-1:0] blkIdx,
  input  logic [NBLK-1:0]  maskIn,
  input  logic             pageDone,
  input  ctlStrobe_t       ctl,
  output logic             writeAllow,
  output logic             protectEn,
  output logic [NBLK-1:0]  lockMask
);

  logic windowOpen;
  logic blkLocked;
  logic globalOk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      protectEn  <= PROT_RESET;
      lockMask   <= LOCK_RESET;
      windowOpen <= 1'b0;
    end else begin
      if (ctl.unlockHit)     protectEn <= 1'b1;
      else if (ctl.protOff)  protectEn <= 1'b0;
      if (ctl.maskLoad)      lockMask  <= maskIn;
      if (ctl.unlockHit)     windowOpen <= 1'b1;
      else if (pageDone)     windowOpen <= 1'b0;
    end
  end

  assign blkLocked  = lockMask[blkIdx];
  assign globalOk   = !protectEn || windowOpen;
  assign writeAllow = wrStrobe && !ctl.consumed && !blkLocked && globalOk;

  // R7: the lock mask only changes after a consumed command cycle
  assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lockMask) |-> $past(wrStrobe && ctl.consumed))
    else $error("lock mask changed outside a command");

  // R4: the page window closes only on the page-end input
  assert_window_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(windowOpen) |-> $past(pageDone))
    else $error("window closed without page end");

endmodule

// File: rtl/wp_guard_top.sv
module wp_guard_top
  import wp_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int NBLK   = 8,
  localparam int CMP_W = ADDR_W - 1,
  localparam int BLK_W = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pageDone,
  output logic              writeAllow,
  output logic              cmdConsumed,
  output logic              protectEn,
  output logic [NBLK-1:0]   lockMask
);

  ctlStrobe_t ctl;

  wp_seq_ctrl #(.CMP_W(CMP_W), .DATA_W(DATA_W)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrStrobe (wrStrobe),
    .addrLow  (wrAddr[CMP_W-1:0]),
    .wrData   (wrData),
    .ctl      (ctl)
  );

  wp_prot_dp #(.NBLK(NBLK)) i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrStrobe   (wrStrobe),
    .blkIdx     (wrAddr[ADDR_W-1 -: BLK_W]),
    .maskIn     (wrData[NBLK-1:0]),
    .pageDone   (pageDone),
    .ctl        (ctl),
    .writeAllow (writeAllow),
    .protectEn  (protectEn),
    .lockMask   (lockMask)
  );

  assign cmdConsumed = ctl.consumed;

  // R2: global protection turns on only after the third key byte
  assert_prot_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(protectEn) |-> $past(wrStrobe && wrAddr[CMP_W-1:0] == 12'h555 && wrData == 8'hA0))
    else $error("protection set without key");

  // R6: global protection turns off only after the off code
  assert_prot_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(protectEn) |-> $past(wrStrobe && wrAddr[CMP_W-1:0] == 12'hAAA && wrData == 8'h80))
    else $error("protection cleared without off code");

  // R10: no decision without a write cycle
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wrStrobe |-> (!writeAllow && !cmdConsumed))
    else $error("output active without strobe");

endmodule

// File: tb/test_wp_guard_top.sv
`timescale 1ns/1ps
module test_wp_guard_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrStrobe = 1'b0;
  logic [12:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        pageDone = 1'b0;
  logic        writeAllow, cmdConsumed, protectEn;
  logic [7:0]  lockMask;

  int total = 0;
  int bad = 0;
  logic gotAllow, gotCons;

  always #5 clk = ~clk;

  wp_guard_top i_wp_guard_top (
    .clk(clk), .rst_n(rst_n), .wrStrobe(wrStrobe), .wrAddr(wrAddr),
    .wrData(wrData), .pageDone(pageDone), .writeAllow(writeAllow),
    .cmdConsumed(cmdConsumed), .protectEn(protectEn), .lockMask(lockMask)
  );

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic doWrite(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    wrStrobe = 1'b1; wrAddr = a; wrData = d;
    #1;
    gotAllow = writeAllow;
    gotCons  = cmdConsumed;
    @(posedge clk); #1;
    wrStrobe = 1'b0;
  endtask

  task automatic cmdWrite(input string tag, input logic [12:0] a, input logic [7:0] d);
    doWrite(a, d);
    check({tag, " consumed"}, gotCons, 1);
    check({tag, " no write"}, gotAllow, 0);
  endtask

  task automatic keyRun(input string tag, input logic hiBit);
    cmdWrite(tag, {hiBit, 12'h555}, 8'hAA);
    cmdWrite(tag, {hiBit, 12'hAAA}, 8'h55);
    cmdWrite(tag, {hiBit, 12'h555}, 8'hA0);
  endtask

  task automatic endPage();
    @(negedge clk); pageDone = 1'b1;
    @(posedge clk); #1; pageDone = 1'b0;
  endtask

  task automatic sweep(input string tag, input logic prot, input logic win, input logic [7:0] m);
    for (int n = 0; n < 8; n++) begin
      for (int e = 0; e < 2; e++) begin
        logic [12:0] a;
        a = 13'(n * 13'h400 + (e == 0 ? 0 : 13'h3FF));
        doWrite(a, 8'h3C);
        check({tag, " consumed"}, gotCons, 0);
        check(tag, gotAllow, (!m[n] && (!prot || win)) ? 1 : 0);
      end
    end
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state, R10 quiet outputs
    check("R1 protectEn", protectEn, 0);
    check("R1 lockMask", lockMask, 0);
    check("R10 allow idle", writeAllow, 0);
    check("R10 consumed idle", cmdConsumed, 0);
    sweep("R1 default", 1'b0, 1'b0, 8'h00);

    // R2 + R5: key with address bit 12 set
    keyRun("R5 key hi", 1'b1);
    check("R2 protectEn set", protectEn, 1);
    endPage();
    // R3: protected, window closed
    sweep("R3 closed", 1'b1, 1'b0, 8'h00);

    // R4: window open for page, closes on pageDone
    keyRun("R2 key", 1'b0);
    sweep("R4 open", 1'b1, 1'b1, 8'h00);
    endPage();
    doWrite(13'h0123, 8'h11);
    check("R4 after page", gotAllow, 0);

    // R9: broken run with window closed
    cmdWrite("R9 start", 13'h0555, 8'hAA);
    doWrite(13'h0100, 8'h12);
    check("R9 break consumed", gotCons, 0);
    check("R9 break closed", gotAllow, 0);
    doWrite(13'h0AAA, 8'h55);
    check("R9 idle no match", gotCons, 0);
    // R9: broken extended run with window open
    keyRun("R9 key", 1'b0);
    cmdWrite("R9 ext", 13'h0555, 8'hAA);
    doWrite(13'h0200, 8'h33);
    check("R9 break consumed open", gotCons, 0);
    check("R9 break open", gotAllow, 1);
    doWrite(13'h0AAA, 8'h55);
    check("R9 stray consumed", gotCons, 0);
    check("R9 stray open", gotAllow, 1);
    endPage();

    // R7: lock-register command, mask byte at unrelated address
    keyRun("R7 key", 1'b0);
    cmdWrite("R7 ext", 13'h0555, 8'hAA);
    cmdWrite("R7 code", 13'h0AAA, 8'hC0);
    cmdWrite("R7 mask", 13'h1FFF, 8'hA5);
    check("R7 lockMask", lockMask, 8'hA5);
    // R8: locked blocks refused with window open
    sweep("R8 open", 1'b1, 1'b1, 8'hA5);
    endPage();
    sweep("R8 closed", 1'b1, 1'b0, 8'hA5);

    // R6: disable command
    keyRun("R6 key", 1'b0);
    cmdWrite("R6 ext", 13'h0555, 8'hAA);
    cmdWrite("R6 code", 13'h0AAA, 8'h80);
    check("R6 protectEn", protectEn, 0);
    check("R6 mask kept", lockMask, 8'hA5);
    endPage();
    // R8: locks hold with protection off
    sweep("R8 unprot", 1'b0, 1'b0, 8'hA5);

    // R7: reload mask with another pattern
    keyRun("R7 key2", 1'b1);
    cmdWrite("R7 ext2", 13'h1555, 8'hAA);
    cmdWrite("R7 code2", 13'h1AAA, 8'hC0);
    cmdWrite("R7 mask2", 13'h0042, 8'h5A);
    check("R7 lockMask2", lockMask, 8'h5A);
    sweep("R8 open2", 1'b1, 1'b1, 8'h5A);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule